// File: doc/BRIEF.md
# Wide Write Splitter

This block accepts one host write of either 32 or 64 bits, together with a byte address and a size flag, and replays it as a series of 16-bit write cycles on a narrow peripheral bus. Every narrow cycle presents a 16-bit word address and 16 bits of data. A valid/ready pair paces the narrow cycles, and the host side sees a ready signal that stays low until the whole series has been acknowledged.

Four configuration inputs are captured with each request. Word swap exchanges the two 16-bit halves of every 32-bit dword. Byte swap then exchanges the two bytes inside every 16-bit word. A hold-address mode sends one chosen word to one fixed word address on every narrow cycle instead of walking through the words, and a 2-bit word select picks that word. A request whose address does not match its size is refused with a one-cycle error pulse and produces no narrow cycles.

Top module: `wide_write_splitter`

## Requirements
- R1: While reset is asserted and right after it, req_ready is 1, bus_valid is 0 and req_err is 0.
- R2: An aligned 64-bit request (req_wide=1) with cfg_hold_addr=0 produces exactly four narrow writes; write k (k=0..3) carries word address req_addr[15:1]+k and data req_data[16k+15:16k] when no swap is set.
- R3: An aligned 32-bit request (req_wide=0) with cfg_hold_addr=0 produces exactly two narrow writes: word address req_addr[15:1] with req_data[15:0], then req_addr[15:1]+1 with req_data[31:16]; req_data[63:32] is unused.
- R4: With cfg_hold_addr=1, a 64-bit request produces four narrow writes, all at word address req_addr[15:1]+s and all carrying word s, where s=cfg_word_sel (00 word0, 01 word1, 10 word2, 11 word3).
- R5: With cfg_hold_addr=1, a 32-bit request produces two narrow writes, both at req_addr[15:1]+cfg_word_sel[0] and both carrying word cfg_word_sel[0]; cfg_word_sel[1] has no effect.
- R6: With cfg_hold_addr=0, cfg_word_sel has no effect on any narrow address or data.
- R7: With cfg_word_swap=1, the word sent in slot k is the one that would have been sent in slot k XOR 1, so the halves of each 32-bit dword are exchanged.
- R8: With cfg_byte_swap=1, the bytes of every 16-bit word are exchanged (bits 7:0 and 15:8); word swap is applied first, and the hold-mode select picks from the swapped data.
- R9: A 64-bit request with req_addr[2:0]!=0, or a 32-bit request with req_addr[1:0]!=0, is accepted, raises req_err for exactly the one cycle after acceptance, and produces no narrow write.
- R10: req_ready is low from the cycle after an aligned request is accepted until the last narrow write is acknowledged, and is high again in the cycle after that acknowledgement.
- R11: While bus_valid is high and bus_ready is low, bus_valid, bus_addr and bus_data hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_byte_swap | input | 1 | Exchange bytes inside each 16-bit word; captured with the request |
| cfg_word_swap | input | 1 | Exchange 16-bit halves of each dword; captured with the request |
| cfg_hold_addr | input | 1 | Repeat one selected word at one fixed address; captured with the request |
| cfg_word_sel | input | 2 | Word chosen in hold-address mode; captured with the request |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a host request |
| req_addr | input | ADDR_W (16) | Host byte address |
| req_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| req_data | input | HOST_W (64) | Host write data, word k in bits 16k+15:16k |
| req_err | output | 1 | One-cycle pulse for a refused misaligned request |
| bus_valid | output | 1 | Narrow write cycle present |
| bus_ready | input | 1 | Narrow bus takes the current cycle |
| bus_addr | output | ADDR_W-1 (15) | Narrow word address |
| bus_data | output | LANE_W (16) | Narrow write data |

## Verification
A corrupted beat index or stored word set shows up at the ports on the very next narrow cycle as a wrong address or data word, and a wrong last-beat value shows as one beat too many or too few, seen when the bus goes idle or req_ready returns too early or too late. A stale hold or select bit appears as an address that moves in hold mode or stays fixed in walking mode within two beats. Random sizes, addresses, swap settings and stall patterns on bus_ready are mixed with directed cases for each select value and for misaligned requests, so every slot of the word mux and both size limits are reached.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } wsplit_state_e;

    // Exchange the two halves of a value of even width
    function automatic logic [15:0] halves_exchange16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

endpackage

// File: rtl/wsplit_swap.sv
module wsplit_swap #(
    parameter int HOST_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [HOST_W-1:0] din,
    input  logic              word_swap,
    input  logic              byte_swap,
    output logic [HOST_W-1:0] dout
);
    localparam int LANES = HOST_W / LANE_W;
    localparam int HALF  = LANE_W / 2;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int PARTNER = l ^ 1;
        logic [LANE_W-1:0] after_ws;

        always_comb begin
            if (word_swap) after_ws = din[PARTNER*LANE_W +: LANE_W];
            else           after_ws = din[l*LANE_W +: LANE_W];
        end

        always_comb begin
            if (byte_swap) dout[l*LANE_W +: LANE_W] = {after_ws[HALF-1:0], after_ws[LANE_W-1:HALF]};
            else           dout[l*LANE_W +: LANE_W] = after_ws;
        end
    end

endmodule

// File: rtl/wsplit_seq.sv
module wsplit_seq
    import wsplit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HOST_W = 64,
    parameter int LANE_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic                                   req_wide,
    input  logic [HOST_W-1:0]                      words_in,
    input  logic                                   hold_in,
    input  logic [$clog2(HOST_W/LANE_W)-1:0]       sel_in,
    output logic                                   req_err,
    output logic                                   bus_valid,
    input  logic                                   bus_ready,
    output logic [ADDR_W-2:0]                      bus_addr,
    output logic [LANE_W-1:0]                      bus_data
);
    localparam int LANES   = HOST_W / LANE_W;
    localparam int IDX_W   = $clog2(LANES);
    localparam int WADDR_W = ADDR_W - 1;
    localparam int WIDE_AB = $clog2(HOST_W / 8);
    localparam int HALF_AB = WIDE_AB - 1;
    localparam logic [IDX_W-1:0] LAST_WIDE = IDX_W'(LANES - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(LANES / 2 - 1);

    typedef struct packed {
        wsplit_state_e      state;
        logic               err;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [WADDR_W-1:0] base;
        logic               hold;
        logic [IDX_W-1:0]   sel;
        logic [HOST_W-1:0]  words;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             misaligned;
    logic [IDX_W-1:0] size_mask;
    logic [IDX_W-1:0] lane;

    always_comb begin
        if (req_wide) begin
            misaligned = |req_addr[WIDE_AB-1:0];
            size_mask  = LAST_WIDE;
        end else begin
            misaligned = |req_addr[HALF_AB-1:0];
            size_mask  = LAST_HALF;
        end
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misaligned) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.state = ST_BUSY;
                        seq_d.idx   = '0;
                        seq_d.last  = size_mask;
                        seq_d.base  = req_addr[ADDR_W-1:1];
                        seq_d.hold  = hold_in;
                        seq_d.sel   = sel_in & size_mask;
                        seq_d.words = words_in;
                    end
                end
            end
            ST_BUSY: begin
                if (bus_ready) begin
                    if (seq_q.idx == seq_q.last) seq_d.state = ST_IDLE;
                    else                         seq_d.idx   = seq_q.idx + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, err: 1'b0, idx: '0, last: '0, base: '0,
                       hold: 1'b0, sel: '0, words: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        lane      = seq_q.hold ? seq_q.sel : seq_q.idx;
        req_ready = (seq_q.state == ST_IDLE);
        req_err   = seq_q.err;
        bus_valid = (seq_q.state == ST_BUSY);
        bus_addr  = seq_q.base + WADDR_W'(lane);
        bus_data  = seq_q.words[lane*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/wide_write_splitter.sv
module wide_write_splitter #(
    parameter  int ADDR_W = 16,
    parameter  int HOST_W = 64,
    parameter  int LANE_W = 16,
    localparam int SEL_W  = $clog2(HOST_W / LANE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_byte_swap,
    input  logic              cfg_word_swap,
    input  logic              cfg_hold_addr,
    input  logic [SEL_W-1:0]  cfg_word_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wide,
    input  logic [HOST_W-1:0] req_data,
    output logic              req_err,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-2:0] bus_addr,
    output logic [LANE_W-1:0] bus_data
);
    logic [HOST_W-1:0] swapped;

    wsplit_swap #(
        .HOST_W (HOST_W),
        .LANE_W (LANE_W)
    ) i_swap (
        .din       (req_data),
        .word_swap (cfg_word_swap),
        .byte_swap (cfg_byte_swap),
        .dout      (swapped)
    );

    wsplit_seq #(
        .ADDR_W (ADDR_W),
        .HOST_W (HOST_W),
        .LANE_W (LANE_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_wide  (req_wide),
        .words_in  (swapped),
        .hold_in   (cfg_hold_addr),
        .sel_in    (cfg_word_sel),
        .req_err   (req_err),
        .bus_valid (bus_valid),
        .bus_ready (bus_ready),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data)
    );

endmodule

// File: rtl/wsplit_chk.sv
module wsplit_chk #(
    parameter int ADDR_W = 16,
    parameter int HOST_W = 64,
    parameter int LANE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_err,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [ADDR_W-2:0] bus_addr,
    input logic [LANE_W-1:0] bus_data
);
    localparam int LANES = HOST_W / LANE_W;
    localparam int CNT_W = $clog2(LANES) + 2;

    logic [CNT_W-1:0] beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    beats <= '0;
        else if (req_valid && req_ready) beats <= '0;
        else if (bus_valid && bus_ready) beats <= beats + 1'b1;
    end

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data)));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    a_r9_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!bus_valid && req_ready));

    a_r9_err_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (req_err || bus_valid));

    a_r2_beat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (beats < CNT_W'(LANES)));

endmodule

bind wide_write_splitter wsplit_chk #(
    .ADDR_W (ADDR_W),
    .HOST_W (HOST_W),
    .LANE_W (LANE_W)
) i_wsplit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_err   (req_err),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data)
);

// File: tb/test_wide_write_splitter.sv
module test_wide_write_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_byte_swap = 1'b0, cfg_word_swap = 1'b0, cfg_hold_addr = 1'b0;
    logic [1:0]  cfg_word_sel = 2'd0;
    logic        req_valid = 1'b0, req_wide = 1'b0, bus_ready = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        req_ready, req_err, bus_valid;
    logic [14:0] bus_addr;
    logic [15:0] bus_data;

    int checks = 0, errors = 0, cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wide_write_splitter i_wide_write_splitter (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [63:0] d, input bit ws, input bit bs, input int k);
        logic [15:0] v;
        v = d[16*(ws ? (k ^ 1) : k) +: 16];
        if (bs) v = {v[7:0], v[15:8]};
        return v;
    endfunction

    task automatic xfer(input logic [15:0] a, input bit wide, input logic [63:0] d, input bit bs,
                        input bit ws, input bit hold, input logic [1:0] sel, input string tag);
        int n, s, beats;
        bit bad;
        logic [14:0] base, ea, last_a;
        logic [15:0] ed, last_d;
        bit stalled;
        bad = wide ? (a[2:0] != 0) : (a[1:0] != 0);
        n = wide ? 4 : 2;
        s = wide ? int'(sel) : int'(sel[0]);
        base = a[15:1];
        req_valid = 1'b1; req_addr = a; req_wide = wide; req_data = d;
        cfg_byte_swap = bs; cfg_word_swap = ws; cfg_hold_addr = hold; cfg_word_sel = sel;
        bus_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // scramble config after capture: must not matter
        cfg_byte_swap = ~bs; cfg_word_swap = ~ws; cfg_hold_addr = ~hold; cfg_word_sel = ~sel;
        req_data = ~d;
        if (bad) begin
            check(req_err == 1'b1 && bus_valid == 1'b0, "R9 err pulse", {req_err, bus_valid}, 2'b10);
            @(negedge clk);
            check(req_err == 1'b0 && bus_valid == 1'b0 && req_ready == 1'b1, "R9 single pulse",
                  {req_err, bus_valid, req_ready}, 3'b001);
            return;
        end
        check(req_err == 1'b0 && req_ready == 1'b0, "R10 busy after accept", {req_err, req_ready}, 2'b00);
        beats = 0;
        stalled = 1'b0;
        while (beats < n) begin
            if (!bus_valid) begin
                check(1'b0, "R10 bus_valid dropped early", beats, n);
                break;
            end
            if (stalled)
                check(bus_addr == last_a && bus_data == last_d, "R11 stable under stall",
                      {bus_addr, bus_data}, {last_a, last_d});
            bus_ready = ($urandom_range(0, 2) != 0);
            if (bus_ready) begin
                ea = hold ? base + 15'(s) : base + 15'(beats);
                ed = exp_word(d, ws, bs, hold ? s : beats);
                check(bus_addr == ea, {tag, " addr"}, bus_addr, ea);
                check(bus_data == ed, {tag, " data"}, bus_data, ed);
                check(req_ready == 1'b0, "R10 ready low mid split", req_ready, 0);
                beats++;
                stalled = 1'b0;
            end else begin
                last_a = bus_addr; last_d = bus_data; stalled = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        bus_ready = 1'b0;
        check(bus_valid == 1'b0 && req_ready == 1'b1, "R10 ready back after last beat",
              {bus_valid, req_ready}, 2'b01);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && bus_valid == 1'b0 && req_err == 1'b0, "R1 in reset",
              {req_ready, bus_valid, req_err}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && bus_valid == 1'b0 && req_err == 1'b0, "R1 after reset",
              {req_ready, bus_valid, req_err}, 3'b100);

        xfer(16'h0100, 1'b1, 64'h4444_3333_2222_1111, 0, 0, 0, 2'd0, "R2");
        xfer(16'h0204, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 2'd0, "R3");
        for (int v = 0; v < 4; v++)
            xfer(16'h0308, 1'b1, 64'hA1A2_B1B2_C1C2_D1D2, 0, 0, 1, 2'(v), "R4");
        xfer(16'h0400, 1'b0, 64'h0123_4567_89AB_CDEF, 0, 0, 1, 2'd3, "R5 upper sel ignored");
        xfer(16'h0404, 1'b0, 64'h0123_4567_89AB_CDEF, 0, 0, 1, 2'd2, "R5 upper sel ignored");
        xfer(16'h0510, 1'b1, 64'h1111_2222_3333_4444, 0, 0, 0, 2'd3, "R6 sel ignored");
        xfer(16'h0600, 1'b1, 64'h1111_2222_3333_4444, 0, 1, 0, 2'd0, "R7");
        xfer(16'h0700, 1'b1, 64'h1122_3344_5566_7788, 1, 0, 0, 2'd0, "R8");
        xfer(16'h0708, 1'b1, 64'h1122_3344_5566_7788, 1, 1, 1, 2'd1, "R8 order and select");
        xfer(16'h0804, 1'b1, 64'h1, 0, 0, 0, 2'd0, "R9");
        xfer(16'h0802, 1'b0, 64'h1, 0, 0, 0, 2'd0, "R9");
        xfer(16'h0801, 1'b1, 64'h1, 0, 0, 1, 2'd0, "R9");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            bit w;
            w = $urandom_range(0, 1) == 1;
            a = 16'($urandom);
            if ($urandom_range(0, 9) != 0) a = w ? {a[15:3], 3'b000} : {a[15:2], 2'b00};
            xfer(a, w, {$urandom, $urandom}, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, 2'($urandom), "R2 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule